// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits beside a receive MAC and decides, frame by frame, whether the frame is kept. The MAC hands it the six bytes of the destination address as a byte stream. The block compares the stream with a programmed station address. It also runs a CRC-32 over the same bytes to pick one bit of a 64-bit multicast hash table. One cycle after the sixth byte it reports an address verdict.

When the MAC later signals end of frame with its CRC-error and over-length status, the block combines those flags with its drop policies. It then reports a final keep or discard verdict. Software programs a small byte-wide register file that holds the receive control byte, the station address and the hash table.

A frame is kept in any of these cases:
- it is unicast and matches the station address exactly;
- it is multicast and its hash bit is set;
- all-multicast mode is on;
- it is broadcast and the broadcast flag is set;
- promiscuous mode is on.

Receive must also be enabled.

Top module: `rx_da_filter`

## Requirements
- R1: Register map, byte wide. The receive control byte is at 0x05. Station address byte i (i = 0..5, byte 0 is the first destination byte on the wire) is at 0x10+i. Hash byte k (k = 0..7) is at 0x16+k. Every register reads back what was last written. All registers are 0 after reset. Any other address reads 0 and ignores writes.
- R2: The hash index is bits 31:26 of a CRC computed over the six destination bytes. The computation seeds the CRC with 0xFFFFFFFF and feeds each byte least significant bit first. For each bit, if (crc[31] XOR bit) the CRC becomes (crc<<1) XOR 0x04C11DB7, otherwise crc<<1. No final inversion is applied.
- R3: Index bits 5:3 select hash byte 0x16+idx[5:3]. Index bits 2:0 select the bit within that byte. Only that single bit influences a multicast verdict.
- R4: A unicast destination (bit 0 of byte 0 clear) is accepted only when all six bytes equal the station address. A mismatch in any byte drops it.
- R5: A non-broadcast multicast destination (bit 0 of byte 0 set) is accepted when its hash bit is 1.
- R6: Control bit 2 (all-multicast) accepts every non-broadcast multicast destination regardless of the hash table.
- R7: The all-ones destination is accepted exactly when bit 7 of hash byte 0x1D is 1 (or promiscuous mode is on). All-multicast mode does not admit it.
- R8: Control bit 1 (promiscuous) accepts every destination.
- R9: With control bit 0 (receive enable) clear, both the address verdict and the final verdict drop every frame, whatever the other bits say.
- R10: Input `da_first` marks byte 0. `addr_done` is a one-cycle pulse in the cycle after the clock edge that captures byte 5, with the verdict on `addr_accept`. Valid bytes after byte 5, or bytes without a preceding `da_first`, are ignored.
- R11: `frame_done` pulses in the cycle after the edge that captures `eof_valid`. `frame_accept` equals the last address verdict, cleared when `eof_crc_err` and control bit 4 are both set, or when `eof_too_long` and control bit 5 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address for write and read |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for cfg_addr, combinational |
| da_valid | input | 1 | Destination address byte valid |
| da_first | input | 1 | Current byte is destination byte 0 |
| da_byte | input | 8 | Destination address byte |
| eof_valid | input | 1 | End-of-frame status valid |
| eof_crc_err | input | 1 | Frame had a CRC error |
| eof_too_long | input | 1 | Frame exceeded maximum length |
| addr_done | output | 1 | Address verdict pulse |
| addr_accept | output | 1 | Address verdict, held until the next one |
| frame_done | output | 1 | Final verdict pulse |
| frame_accept | output | 1 | Final verdict, held until the next one |

## Verification
The address verdict is registered at the same edge that captures destination byte 5. The bench therefore drives each byte on a falling edge and samples `addr_done` and `addr_accept` on the falling edge right after the sixth byte's rising edge. One falling edge later it confirms the pulse has gone. The end-of-frame verdict also lands one edge after `eof_valid` and is sampled the same way. Register reads are combinational and are checked a short delay after the address settles. Extra bytes past the sixth are driven, and the bench confirms that no second pulse appears and that the held verdict is unchanged.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam logic [7:0] CTL_ADDR  = 8'h05;
  localparam logic [7:0] STA_BASE  = 8'h10;
  localparam logic [7:0] HASH_BASE = 8'h16;

  localparam int CTL_RX_EN     = 0;
  localparam int CTL_PROMISC   = 1;
  localparam int CTL_ALL_MC    = 2;
  localparam int CTL_DROP_CRC  = 4;
  localparam int CTL_DROP_LONG = 5;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  // Advance the hash CRC by one byte, least significant bit first.
  function automatic logic [31:0] crc_step(input logic [31:0] crc_in,
                                           input logic [7:0]  data);
    logic [31:0] c;
    c = crc_in;
    for (int b = 0; b < 8; b++) begin
      if (c[31] ^ data[b]) c = {c[30:0], 1'b0} ^ CRC_POLY;
      else                 c = {c[30:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
#(
  parameter int STA_BYTES  = 6,
  parameter int HASH_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    we,
  input  logic [7:0]              addr,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  output logic                    rx_en,
  output logic                    promisc,
  output logic                    all_mc,
  output logic                    drop_crc,
  output logic                    drop_long,
  output logic [STA_BYTES*8-1:0]  sta,
  output logic [HASH_BYTES*8-1:0] hash
);

  logic [7:0] ctl_q, ctl_d;
  logic       ctl_en;

  assign ctl_en = we && (addr == CTL_ADDR);
  assign ctl_d  = wdata;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < STA_BYTES; gi++) begin : g_sta
      logic [7:0] q;
      logic       en;
      assign en = we && (addr == STA_BASE + 8'(gi));
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (en) q <= wdata;
      end
      assign sta[gi*8 +: 8] = q;
    end
    for (gi = 0; gi < HASH_BYTES; gi++) begin : g_hash
      logic [7:0] q;
      logic       en;
      assign en = we && (addr == HASH_BASE + 8'(gi));
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (en) q <= wdata;
      end
      assign hash[gi*8 +: 8] = q;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (addr == CTL_ADDR) rdata = ctl_q;
    for (int i = 0; i < STA_BYTES; i++)
      if (addr == STA_BASE + 8'(i)) rdata = sta[i*8 +: 8];
    for (int i = 0; i < HASH_BYTES; i++)
      if (addr == HASH_BASE + 8'(i)) rdata = hash[i*8 +: 8];
  end

  assign rx_en     = ctl_q[CTL_RX_EN];
  assign promisc   = ctl_q[CTL_PROMISC];
  assign all_mc    = ctl_q[CTL_ALL_MC];
  assign drop_crc  = ctl_q[CTL_DROP_CRC];
  assign drop_long = ctl_q[CTL_DROP_LONG];

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !$past(ctl_en) |-> $stable(ctl_q)); // R1

endmodule

// File: rtl/rxf_match.sv
module rxf_match #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    valid,
  input  logic                    first,
  input  logic [7:0]              data,
  input  logic [ADDR_BYTES*8-1:0] sta,
  output logic                    take,
  output logic                    last,
  output logic                    uc_hit_nxt,
  output logic                    mc_nxt,
  output logic                    bc_nxt
);

  localparam int CW = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] LAST_POS = CW'(ADDR_BYTES - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(ADDR_BYTES);

  logic [CW-1:0] cnt_q, cnt_d, pos;
  logic          eq_q, eq_d, mc_q, mc_d, bc_q, bc_d;
  logic [7:0]    sta_b;

  assign pos  = first ? '0 : cnt_q;
  assign take = valid && (first || ((cnt_q != '0) && (cnt_q < FULL_CNT)));
  assign last = take && (pos == LAST_POS);

  always_comb begin
    sta_b = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (pos == CW'(i)) sta_b = sta[i*8 +: 8];
  end

  always_comb begin
    cnt_d = pos + CW'(1);
    eq_d  = (first ? 1'b1 : eq_q) && (data == sta_b);
    mc_d  = first ? data[0] : mc_q;
    bc_d  = (first ? 1'b1 : bc_q) && (data == 8'hFF);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      eq_q  <= 1'b0;
      mc_q  <= 1'b0;
      bc_q  <= 1'b0;
    end else if (take) begin
      cnt_q <= cnt_d;
      eq_q  <= eq_d;
      mc_q  <= mc_d;
      bc_q  <= bc_d;
    end
  end

  assign uc_hit_nxt = eq_d;
  assign mc_nxt     = mc_d;
  assign bc_nxt     = bc_d;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= FULL_CNT); // R10
  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_ni)
    (valid && !first && cnt_q == FULL_CNT) |=> (cnt_q == FULL_CNT)); // R10

endmodule

// File: rtl/rxf_hash.sv
module rxf_hash
  import rxf_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             take,
  input  logic             first,
  input  logic [7:0]       data,
  output logic [IDX_W-1:0] idx_nxt
);

  logic [31:0] crc_q, crc_d;

  assign crc_d   = crc_step(first ? CRC_SEED : crc_q, data);
  assign idx_nxt = crc_d[31 -: IDX_W];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= CRC_SEED;
    else if (take) crc_q <= crc_d;
  end

  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !take |=> $stable(crc_q)); // R2

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       da_valid,
  input  logic       da_first,
  input  logic [7:0] da_byte,
  input  logic       eof_valid,
  input  logic       eof_crc_err,
  input  logic       eof_too_long,
  output logic       addr_done,
  output logic       addr_accept,
  output logic       frame_done,
  output logic       frame_accept
);

  localparam int HASH_BITS = HASH_BYTES * 8;
  localparam int IDX_W     = $clog2(HASH_BITS);

  // asynchronous assert, synchronous release
  logic rst_s1, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ni <= rst_s1;
    end
  end

  logic                    rx_en, promisc, all_mc, drop_crc, drop_long;
  logic [ADDR_BYTES*8-1:0] sta;
  logic [HASH_BITS-1:0]    hash;
  logic                    take, last, uc_hit, mc, bc;
  logic [IDX_W-1:0]        idx;

  rxf_regs #(.STA_BYTES(ADDR_BYTES), .HASH_BYTES(HASH_BYTES)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .rx_en(rx_en), .promisc(promisc),
    .all_mc(all_mc), .drop_crc(drop_crc), .drop_long(drop_long),
    .sta(sta), .hash(hash)
  );

  rxf_match #(.ADDR_BYTES(ADDR_BYTES)) u_match (
    .clk(clk), .rst_ni(rst_ni), .valid(da_valid), .first(da_first),
    .data(da_byte), .sta(sta), .take(take), .last(last),
    .uc_hit_nxt(uc_hit), .mc_nxt(mc), .bc_nxt(bc)
  );

  rxf_hash #(.IDX_W(IDX_W)) u_hash (
    .clk(clk), .rst_ni(rst_ni), .take(take), .first(da_first),
    .data(da_byte), .idx_nxt(idx)
  );

  // byte idx[5:3], bit idx[2:0] is simply flat bit idx of the table
  logic hash_hit, bc_flag, verdict, fverdict;
  assign hash_hit = hash[idx];
  assign bc_flag  = hash[HASH_BITS-1];

  always_comb begin
    if (bc)      verdict = bc_flag;
    else if (mc) verdict = all_mc || hash_hit;
    else         verdict = uc_hit;
    verdict = rx_en && (promisc || verdict);
  end

  assign fverdict = rx_en && addr_accept &&
                    !(eof_crc_err && drop_crc) &&
                    !(eof_too_long && drop_long);

  logic adone_d, aacc_d, fdone_d, facc_d;
  always_comb begin
    adone_d = last;
    aacc_d  = last ? verdict : addr_accept;
    fdone_d = eof_valid;
    facc_d  = eof_valid ? fverdict : frame_accept;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_done    <= 1'b0;
      addr_accept  <= 1'b0;
      frame_done   <= 1'b0;
      frame_accept <= 1'b0;
    end else begin
      addr_done    <= adone_d;
      addr_accept  <= aacc_d;
      frame_done   <= fdone_d;
      frame_accept <= facc_d;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    addr_done |=> !addr_done); // R10
  AST_HOLD_VERDICT: assert property (@(posedge clk) disable iff (!rst_ni)
    !addr_done |-> $stable(addr_accept)); // R10
  AST_RXOFF_DROP: assert property (@(posedge clk) disable iff (!rst_ni)
    (last && !rx_en) |=> !addr_accept); // R9
  AST_PROMISC_KEEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (last && rx_en && promisc) |=> addr_accept); // R8
  AST_CRC_DROP: assert property (@(posedge clk) disable iff (!rst_ni)
    (eof_valid && eof_crc_err && drop_crc) |=> !frame_accept); // R11
  AST_LONG_DROP: assert property (@(posedge clk) disable iff (!rst_ni)
    (eof_valid && eof_too_long && drop_long) |=> !frame_accept); // R11

endmodule

// File: tb/test_rx_da_filter.sv
module test_rx_da_filter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_addr, cfg_wdata, cfg_rdata;
  logic       da_valid, da_first;
  logic [7:0] da_byte;
  logic       eof_valid, eof_crc_err, eof_too_long;
  logic       addr_done, addr_accept, frame_done, frame_accept;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rx_da_filter i_rx_da_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .da_valid(da_valid),
    .da_first(da_first), .da_byte(da_byte), .eof_valid(eof_valid),
    .eof_crc_err(eof_crc_err), .eof_too_long(eof_too_long),
    .addr_done(addr_done), .addr_accept(addr_accept),
    .frame_done(frame_done), .frame_accept(frame_accept)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] hidx(input logic [47:0] da);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++)
      for (int b = 0; b < 8; b++)
        if (c[31] ^ da[47 - i*8 - 7 + b]) c = {c[30:0], 1'b0} ^ 32'h04C1_1DB7;
        else                              c = {c[30:0], 1'b0};
    return c[31:26];
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a,
                          input logic [7:0] exp);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  // da[47:40] is byte 0 on the wire
  task automatic set_sta(input logic [47:0] da);
    for (int i = 0; i < 6; i++) wr(8'h10 + 8'(i), da[47 - i*8 -: 8]);
  endtask

  task automatic set_hash(input logic [63:0] h);
    for (int k = 0; k < 8; k++) wr(8'h16 + 8'(k), h[k*8 +: 8]);
  endtask

  task automatic send(input string req, input logic [47:0] da, input logic exp);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      da_valid = 1'b1; da_first = (i == 0); da_byte = da[47 - i*8 -: 8];
    end
    @(negedge clk);
    da_valid = 1'b0; da_first = 1'b0;
    check({req, " done"}, addr_done, 1'b1);
    check({req, " accept"}, addr_accept, exp);
    @(negedge clk);
    check({req, " pulse"}, addr_done, 1'b0);
  endtask

  task automatic eof(input string req, input logic ce, input logic tl,
                     input logic exp);
    @(negedge clk);
    eof_valid = 1'b1; eof_crc_err = ce; eof_too_long = tl;
    @(negedge clk);
    eof_valid = 1'b0; eof_crc_err = 1'b0; eof_too_long = 1'b0;
    check({req, " frame_done"}, frame_done, 1'b1);
    check({req, " frame_accept"}, frame_accept, exp);
  endtask

  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
  localparam logic [47:0] MCA = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] BCA = 48'hFF_FF_FF_FF_FF_FF;

  task automatic t_reset;
    check("R1 reset addr_done", addr_done, 1'b0);
    check("R1 reset addr_accept", addr_accept, 1'b0);
    check("R1 reset frame_done", frame_done, 1'b0);
    rd_check("R1 reset ctl", 8'h05, 8'h00);
    rd_check("R1 reset sta", 8'h12, 8'h00);
    rd_check("R1 reset hash", 8'h1D, 8'h00);
  endtask

  task automatic t_regs;
    wr(8'h05, 8'h35);
    set_sta(STA);
    set_hash(64'h8877_6655_4433_2211);
    wr(8'h1E, 8'hAB);
    rd_check("R1 ctl", 8'h05, 8'h35);
    rd_check("R1 sta0", 8'h10, 8'h02);
    rd_check("R1 sta5", 8'h15, 8'h55);
    rd_check("R1 hash0", 8'h16, 8'h11);
    rd_check("R1 hash7", 8'h1D, 8'h88);
    rd_check("R1 unmapped", 8'h1E, 8'h00);
  endtask

  task automatic t_unicast;
    wr(8'h05, 8'h01);
    set_hash(64'h0);
    send("R4 exact", STA, 1'b1);
    send("R4 last byte differs", STA ^ 48'h1, 1'b0);
    send("R4 first byte differs", STA ^ 48'h04_00_00_00_00_00, 1'b0);
  endtask

  task automatic t_hash;
    logic [5:0] ix;
    ix = hidx(MCA);
    wr(8'h05, 8'h01);
    set_hash(64'h0);
    send("R5 empty table", MCA, 1'b0);
    set_hash(64'h1 << ix);
    send("R2 R3 R5 own bit", MCA, 1'b1);
    set_hash(~(64'h1 << ix));
    send("R3 all other bits", MCA, 1'b0);
  endtask

  task automatic t_allmc;
    wr(8'h05, 8'h05);
    set_hash(64'h0);
    send("R6 all-multicast", MCA, 1'b1);
    send("R6 unicast still exact", STA ^ 48'h10, 1'b0);
    send("R7 all-mc no broadcast", BCA, 1'b0);
  endtask

  task automatic t_bcast;
    wr(8'h05, 8'h01);
    set_hash(64'h7FFF_FFFF_FFFF_FFFF);
    send("R7 flag clear", BCA, 1'b0);
    set_hash(64'h8000_0000_0000_0000);
    send("R7 flag set", BCA, 1'b1);
  endtask

  task automatic t_promisc;
    wr(8'h05, 8'h03);
    set_hash(64'h0);
    send("R8 promisc unicast", 48'h00_AA_BB_CC_DD_EE, 1'b1);
    send("R8 promisc broadcast", BCA, 1'b1);
  endtask

  task automatic t_rxoff;
    wr(8'h05, 8'h06);
    set_hash(64'hFFFF_FFFF_FFFF_FFFF);
    send("R9 off unicast", STA, 1'b0);
    send("R9 off broadcast", BCA, 1'b0);
    eof("R9 off frame", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_extra;
    wr(8'h05, 8'h01);
    send("R10 match", STA, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      da_valid = 1'b1; da_first = 1'b0; da_byte = 8'h99;
    end
    @(negedge clk);
    da_valid = 1'b0;
    @(negedge clk);
    check("R10 extra bytes no pulse", addr_done, 1'b0);
    check("R10 verdict held", addr_accept, 1'b1);
  endtask

  task automatic t_eof;
    wr(8'h05, 8'h31);
    send("R11 setup", STA, 1'b1);
    eof("R11 clean", 1'b0, 1'b0, 1'b1);
    eof("R11 crc dropped", 1'b1, 1'b0, 1'b0);
    eof("R11 long dropped", 1'b0, 1'b1, 1'b0);
    wr(8'h05, 8'h01);
    eof("R11 policies off", 1'b1, 1'b1, 1'b1);
    send("R11 drop addr", STA ^ 48'h2, 1'b0);
    eof("R11 address dropped", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    da_valid = 1'b0; da_first = 1'b0; da_byte = '0;
    eof_valid = 1'b0; eof_crc_err = 1'b0; eof_too_long = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_regs;
    t_unicast;
    t_hash;
    t_allmc;
    t_bcast;
    t_promisc;
    t_rxoff;
    t_extra;
    t_eof;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule